// File: doc/BRIEF.md
# Clock Output Gating and Select Controller

This block sits between the frequency synthesizer and the output pads of a multi-output clock generator. It takes the finished source clocks (CPU, PCI, AGP, reference, 48 MHz and 24 MHz) as inputs and decides, per output, whether each of 27 outputs toggles, is held low, or is released to high impedance. It also latches the power-up strap pins and derives the frequency-select code and the SDRAM source choice from them.

After reset a strap window of `STRAP_CYCLES` reference-clock cycles runs. During the window all clocks are held low, and the pins that double as strap inputs are released so that their strap resistors set the level. At the end of the window the straps are latched once. From then on the gating request for each output merges four things in a fixed order. The global high-impedance code comes first, then power-down, then the three stop inputs, then the per-output enable bits. A mode strap decides whether four SDRAM pins are clock outputs or active-low control inputs.

Each request is registered in the reference domain. It then passes through a `SYNC_STAGES` synchronizer on its own source clock, and a gate register updates it on the falling edge of that clock. An output therefore starts or stops only while its source is low, and never produces a shortened pulse.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While reset is asserted, every clk_o bit and every oe_o bit is 0. For the first STRAP_CYCLES rising edges of clk_ref after reset, all clocks are held low. During that time oe_o is 0 for the strap-capable pins, which are index 9 (free PCI), 11 (free AGP), 24 (REF), 25 (48 MHz) and 26 (24 MHz), and for the shared pins 16 to 19. oe_o is 1 for every other output unless R11 applies.
- R2: On the STRAP_CYCLES-th rising edge of clk_ref after reset, strap_fs_i, strap_mode_i and strap_sdsel_i are latched. Later changes on those pins have no effect until the next reset.
- R3: freq_sel_o equals cfg_fs_i while cfg_fs_ovr_i is 1, and equals the latched strap_fs_i while it is 0. Before the latch, the latched value is 0.
- R4: sdram_on_cpu_o is the latched strap_sdsel_i (1 = SDRAM outputs 12 to 23 run from clk_cpu, 0 = from clk_agp). It is 0 before the latch.
- R5: With the latched mode 0, outputs 16 to 19 have oe_o = 0 and clk_o held low. The pins share_pin_i[0..3] then act as active-low AGP stop, power-down, CPU stop and PCI stop, in that order.
- R6: With CPU stop low, outputs 0 to 3 (CPU) and 12 to 23 (SDRAM) are held low.
- R7: With PCI stop low, outputs 4 to 8 are held low while output 9 (free PCI) keeps running.
- R8: With AGP stop low, output 10 is held low while output 11 (free AGP) keeps running.
- R9: With power-down low, all 27 clocks are held low.
- R10: A 0 in cfg_en_i[i] holds clk_o[i] low, with the index map CPU 0-3, PCI 4-8, free PCI 9, AGP 10, free AGP 11, SDRAM 12-23, REF 24, 48 MHz 25, 24 MHz 26.
- R11: cfg_op_i = 2'b11 drives every oe_o bit to 0 and stops every clock, and this overrides power-down and stops. 2'b10 sets spread_en_o. 2'b00 and the reserved 2'b01 give normal operation with spread_en_o = 0.
- R12: A request sampled on a clk_ref rising edge reaches clk_o after SYNC_STAGES+1 further rising edges of the source clock, via the falling edge before that. clk_o is always 0 while its source clock is low.
- R13: With the latched mode 1, share_pin_i has no effect, and outputs 16 to 19 are driven clock outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; control domain and source of output 24 |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cpu | input | 1 | CPU source clock |
| clk_agp | input | 1 | AGP source clock |
| clk_pci | input | 1 | PCI source clock |
| clk_48 | input | 1 | 48 MHz source clock |
| clk_24 | input | 1 | 24 MHz source clock |
| strap_fs_i | input | 3 | Frequency strap pin levels |
| strap_mode_i | input | 1 | Mode strap pin level |
| strap_sdsel_i | input | 1 | SDRAM source strap pin level |
| share_pin_i | input | 4 | Levels on the four shared SDRAM/control pins |
| cfg_fs_ovr_i | input | 1 | 1 selects the register frequency code |
| cfg_fs_i | input | 3 | Register frequency code |
| cfg_op_i | input | 2 | Operating code: normal, reserved, spread, high-Z |
| cfg_en_i | input | 27 | Per-output enable, 1 = may run |
| clk_o | output | 27 | Gated clock outputs |
| oe_o | output | 27 | Per-output pad drive enable |
| freq_sel_o | output | 3 | Selected frequency code |
| sdram_on_cpu_o | output | 1 | SDRAM source select |
| spread_en_o | output | 1 | Spread modulation request |

## Verification
The corner cases are the free-running PCI and AGP outputs under their stop inputs. A design that lumped them with their stoppable siblings would silence a clock that must keep running. The bench also swaps the mode strap between two reset sessions, because a design that decoded the shared pins without regard to the latched mode would stop clocks from what are really SDRAM outputs, or drive pins that are inputs. Strap pins are moved after the latch to catch a design that samples them continuously. The high-Z code is combined with power-down to expose a wrong precedence. Every output is compared on every cycle against a model that delays requests by the synchronizer depth, so a stage too many or too few shows up as a one-cycle mismatch. The low phase is also checked, so any gate that changes while its source is high shows up as a pulse.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int N_CPU      = 4;
    localparam int N_PCI      = 5;
    localparam int N_SDR      = 12;
    localparam int N_SHARE    = 4;
    localparam int FS_W       = 3;

    localparam int IDX_CPU0   = 0;
    localparam int IDX_PCI0   = IDX_CPU0 + N_CPU;
    localparam int IDX_PCIF   = IDX_PCI0 + N_PCI;
    localparam int IDX_AGP0   = IDX_PCIF + 1;
    localparam int IDX_AGPF   = IDX_AGP0 + 1;
    localparam int IDX_SDR0   = IDX_AGPF + 1;
    localparam int IDX_REF    = IDX_SDR0 + N_SDR;
    localparam int IDX_48     = IDX_REF + 1;
    localparam int IDX_24     = IDX_48 + 1;
    localparam int N_OUT      = IDX_24 + 1;
    localparam int SHARE_BASE = IDX_SDR0 + 4;

    // role of each shared pin when the mode strap is 0 (all active low)
    localparam int SH_AGP_STOP = 0;
    localparam int SH_PWR_DOWN = 1;
    localparam int SH_CPU_STOP = 2;
    localparam int SH_PCI_STOP = 3;

    typedef enum logic [2:0] {
        SRC_CPU, SRC_PCI, SRC_AGP, SRC_SDR, SRC_REF, SRC_48, SRC_24
    } src_e;

    typedef enum logic [1:0] {
        OP_NORMAL = 2'b00,
        OP_RSVD   = 2'b01,
        OP_SPREAD = 2'b10,
        OP_HIZ    = 2'b11
    } op_e;

    typedef struct packed {
        logic [N_OUT-1:0] req;
        logic [N_OUT-1:0] oe;
    } gate_ctl_t;

    function automatic logic [N_OUT-1:0] span(int lo, int n);
        logic [N_OUT-1:0] m;
        for (int k = 0; k < N_OUT; k++) begin
            m[k] = (k >= lo) && (k < lo + n);
        end
        return m;
    endfunction

    function automatic src_e src_of(int i);
        if (i < IDX_PCI0)       return SRC_CPU;
        else if (i <= IDX_PCIF) return SRC_PCI;
        else if (i <= IDX_AGPF) return SRC_AGP;
        else if (i < IDX_REF)   return SRC_SDR;
        else if (i == IDX_REF)  return SRC_REF;
        else if (i == IDX_48)   return SRC_48;
        else                    return SRC_24;
    endfunction

    localparam logic [N_OUT-1:0] CPU_M  = span(IDX_CPU0, N_CPU);
    localparam logic [N_OUT-1:0] PCI_M  = span(IDX_PCI0, N_PCI);
    localparam logic [N_OUT-1:0] AGP_M  = span(IDX_AGP0, 1);
    localparam logic [N_OUT-1:0] SDR_M  = span(IDX_SDR0, N_SDR);
    localparam logic [N_OUT-1:0] SHR_M  = span(SHARE_BASE, N_SHARE);
    localparam logic [N_OUT-1:0] DUAL_M = span(IDX_PCIF, 1) | span(IDX_AGPF, 1)
                                        | span(IDX_REF, 3);

endpackage

// File: rtl/cgc_strap_latch.sv
module cgc_strap_latch
    import clkgate_pkg::*;
#(
    parameter int STRAP_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] strap_fs_i,
    input  logic            strap_mode_i,
    input  logic            strap_sdsel_i,
    output logic            done_o,
    output logic [FS_W-1:0] fs_o,
    output logic            mode_o,
    output logic            sdsel_o
);

    localparam int CW = $clog2(STRAP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STRAP_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic            done;
        logic [FS_W-1:0] fs;
        logic            mode;
        logic            sdsel;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (st_q.cnt == LAST) begin
                // end of window: capture pin levels once
                st_d.done  = 1'b1;
                st_d.fs    = strap_fs_i;
                st_d.mode  = strap_mode_i;
                st_d.sdsel = strap_sdsel_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o  = st_q.done;
    assign fs_o    = st_q.fs;
    assign mode_o  = st_q.mode;
    assign sdsel_o = st_q.sdsel;

endmodule

// File: rtl/cgc_request.sv
module cgc_request
    import clkgate_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  logic               mode_i,
    input  logic [N_SHARE-1:0] share_pin_i,
    input  logic [1:0]         cfg_op_i,
    input  logic [N_OUT-1:0]   cfg_en_i,
    output logic [N_OUT-1:0]   req_o,
    output logic [N_OUT-1:0]   oe_o
);

    gate_ctl_t ctl_d, ctl_q;

    logic hiz, pins_are_ctl, pwr_down, cpu_stop, pci_stop, agp_stop;

    always_comb begin
        hiz          = (op_e'(cfg_op_i) == OP_HIZ);
        pins_are_ctl = done_i && !mode_i;
        pwr_down     = pins_are_ctl && !share_pin_i[SH_PWR_DOWN];
        cpu_stop     = pins_are_ctl && !share_pin_i[SH_CPU_STOP];
        pci_stop     = pins_are_ctl && !share_pin_i[SH_PCI_STOP];
        agp_stop     = pins_are_ctl && !share_pin_i[SH_AGP_STOP];

        // pad drive: high-Z code, then strap window, then shared-pin inputs
        if (hiz) begin
            ctl_d.oe = '0;
        end else if (!done_i) begin
            ctl_d.oe = ~(DUAL_M | SHR_M);
        end else if (!mode_i) begin
            ctl_d.oe = ~SHR_M;
        end else begin
            ctl_d.oe = '1;
        end

        // run request: high-Z, power-down, stops, then per-output enables
        if (!done_i || hiz || pwr_down) begin
            ctl_d.req = '0;
        end else begin
            ctl_d.req = cfg_en_i;
            if (cpu_stop)     ctl_d.req = ctl_d.req & ~(CPU_M | SDR_M);
            if (pci_stop)     ctl_d.req = ctl_d.req & ~PCI_M;
            if (agp_stop)     ctl_d.req = ctl_d.req & ~AGP_M;
            if (pins_are_ctl) ctl_d.req = ctl_d.req & ~SHR_M;
        end
    end

    // the share pins are asynchronous; this register is the first capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_o = ctl_q.req;
    assign oe_o  = ctl_q.oe;

endmodule

// File: rtl/cgc_out_gate.sv
module cgc_out_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req_i,
    output logic clk_o
);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   gate_d, gate_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_comb sync_d = req_i;
        end else begin : g_many
            always_comb sync_d = {sync_q[SYNC_STAGES-2:0], req_i};
        end
    endgenerate

    always_comb gate_d = sync_q[SYNC_STAGES-1];

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // gate moves only on the falling edge, while the source is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign clk_o = src_clk & gate_q;

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int STRAP_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               clk_cpu,
    input  logic               clk_agp,
    input  logic               clk_pci,
    input  logic               clk_48,
    input  logic               clk_24,
    input  logic [FS_W-1:0]    strap_fs_i,
    input  logic               strap_mode_i,
    input  logic               strap_sdsel_i,
    input  logic [N_SHARE-1:0] share_pin_i,
    input  logic               cfg_fs_ovr_i,
    input  logic [FS_W-1:0]    cfg_fs_i,
    input  logic [1:0]         cfg_op_i,
    input  logic [N_OUT-1:0]   cfg_en_i,
    output logic [N_OUT-1:0]   clk_o,
    output logic [N_OUT-1:0]   oe_o,
    output logic [FS_W-1:0]    freq_sel_o,
    output logic               sdram_on_cpu_o,
    output logic               spread_en_o
);

    logic            strap_done;
    logic [FS_W-1:0] strap_fs;
    logic            strap_mode;
    logic            strap_sdsel;
    logic [N_OUT-1:0] req;
    logic            clk_sdr;

    cgc_strap_latch #(.STRAP_CYCLES(STRAP_CYCLES)) u_strap (
        .clk           (clk_ref),
        .rst_n         (rst_n),
        .strap_fs_i    (strap_fs_i),
        .strap_mode_i  (strap_mode_i),
        .strap_sdsel_i (strap_sdsel_i),
        .done_o        (strap_done),
        .fs_o          (strap_fs),
        .mode_o        (strap_mode),
        .sdsel_o       (strap_sdsel)
    );

    cgc_request u_req (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .done_i      (strap_done),
        .mode_i      (strap_mode),
        .share_pin_i (share_pin_i),
        .cfg_op_i    (cfg_op_i),
        .cfg_en_i    (cfg_en_i),
        .req_o       (req),
        .oe_o        (oe_o)
    );

    // SDRAM source is fixed once straps are latched; gates are closed before
    assign clk_sdr = strap_sdsel ? clk_cpu : clk_agp;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        localparam src_e SRC = src_of(g);
        logic src_clk;

        always_comb begin
            unique case (SRC)
                SRC_CPU: src_clk = clk_cpu;
                SRC_PCI: src_clk = clk_pci;
                SRC_AGP: src_clk = clk_agp;
                SRC_SDR: src_clk = clk_sdr;
                SRC_REF: src_clk = clk_ref;
                SRC_48:  src_clk = clk_48;
                default: src_clk = clk_24;
            endcase
        end

        cgc_out_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .src_clk (src_clk),
            .rst_n   (rst_n),
            .req_i   (req[g]),
            .clk_o   (clk_o[g])
        );
    end

    assign freq_sel_o     = cfg_fs_ovr_i ? cfg_fs_i : strap_fs;
    assign sdram_on_cpu_o = strap_sdsel;
    assign spread_en_o    = (op_e'(cfg_op_i) == OP_SPREAD);

endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk
    import clkgate_pkg::*;
(
    input logic               clk_ref,
    input logic               rst_n,
    input logic [N_SHARE-1:0] share_pin_i,
    input logic [1:0]         cfg_op_i,
    input logic [N_OUT-1:0]   cfg_en_i,
    input logic [N_OUT-1:0]   oe_o,
    input logic               strap_done,
    input logic               strap_mode,
    input logic [FS_W-1:0]    strap_fs,
    input logic [N_OUT-1:0]   req
);

    p_hiz_all_r11: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cfg_op_i == 2'b11) |=> (oe_o == '0 && req == '0));

    p_pwrdown_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && !strap_mode && !share_pin_i[SH_PWR_DOWN]) |=> (req == '0));

    p_cpu_stop_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && !strap_mode && !share_pin_i[SH_CPU_STOP])
        |=> ((req & (CPU_M | SDR_M)) == '0));

    p_free_pci_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && cfg_op_i != 2'b11 && cfg_en_i[IDX_PCIF]
         && (strap_mode || share_pin_i[SH_PWR_DOWN]))
        |=> req[IDX_PCIF]);

    p_shared_input_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (strap_done && !strap_mode) |=> ((oe_o & SHR_M) == '0));

    p_strap_hold_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        strap_done |=> (strap_done && $stable(strap_mode) && $stable(strap_fs)));

endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk u_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .share_pin_i (share_pin_i),
    .cfg_op_i    (cfg_op_i),
    .cfg_en_i    (cfg_en_i),
    .oe_o        (oe_o),
    .strap_done  (strap_done),
    .strap_mode  (strap_mode),
    .strap_fs    (strap_fs),
    .req         (req)
);

// File: tb/tb_clk_gate_ctrl.sv
module tb_clk_gate_ctrl;

    localparam int NO    = 27;
    localparam int STRAP = 16;
    localparam int SYNC  = 2;
    localparam int DLY   = SYNC + 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [2:0]    strap_fs;
    logic          strap_mode, strap_sdsel;
    logic [3:0]    share;
    logic          fs_ovr;
    logic [2:0]    cfg_fs;
    logic [1:0]    op;
    logic [NO-1:0] en;
    logic [NO-1:0] clk_o, oe_o;
    logic [2:0]    freq;
    logic          sd_cpu, spread;

    clk_gate_ctrl #(.STRAP_CYCLES(STRAP), .SYNC_STAGES(SYNC)) dut (
        .clk_ref(clk), .rst_n(rst_n), .clk_cpu(clk), .clk_agp(clk), .clk_pci(clk),
        .clk_48(clk), .clk_24(clk), .strap_fs_i(strap_fs), .strap_mode_i(strap_mode),
        .strap_sdsel_i(strap_sdsel), .share_pin_i(share), .cfg_fs_ovr_i(fs_ovr),
        .cfg_fs_i(cfg_fs), .cfg_op_i(op), .cfg_en_i(en), .clk_o(clk_o), .oe_o(oe_o),
        .freq_sel_o(freq), .sdram_on_cpu_o(sd_cpu), .spread_en_o(spread)
    );

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string tag = "R1";

    function automatic logic [NO-1:0] rng(int lo, int hi);
        logic [NO-1:0] m = '0;
        for (int k = lo; k <= hi; k++) m[k] = 1'b1;
        return m;
    endfunction

    // index map from the requirements
    logic [NO-1:0] m_cpu, m_pci, m_agp0, m_sdr, m_shr, m_dual;
    initial begin
        m_cpu  = rng(0, 3);
        m_pci  = rng(4, 8);
        m_agp0 = rng(10, 10);
        m_sdr  = rng(12, 23);
        m_shr  = rng(16, 19);
        m_dual = rng(9, 9) | rng(11, 11) | rng(24, 26);
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // reference model state
    int            cnt_m;
    logic          done_m, mode_m, sd_m;
    logic [2:0]    fs_m;
    logic [NO-1:0] hist [DLY];
    logic [NO-1:0] oe_m;

    always @(posedge clk) begin
        logic [NO-1:0] r, o;
        logic ctl, hz;
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (!rst_n) begin
            cnt_m = 0; done_m = 0; mode_m = 0; sd_m = 0; fs_m = '0; oe_m = '0;
            for (int k = 0; k < DLY; k++) hist[k] = '0;
        end else begin
            hz  = (op == 2'b11);
            ctl = done_m && !mode_m;
            if (hz)          o = '0;
            else if (!done_m) o = ~(m_dual | m_shr);
            else if (!mode_m) o = ~m_shr;
            else              o = '1;
            if (!done_m || hz || (ctl && !share[1])) r = '0;
            else begin
                r = en;
                if (ctl && !share[2]) r &= ~(m_cpu | m_sdr);
                if (ctl && !share[3]) r &= ~m_pci;
                if (ctl && !share[0]) r &= ~m_agp0;
                if (ctl)              r &= ~m_shr;
            end
            for (int k = DLY - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = r;
            oe_m = o;
            if (!done_m) begin
                if (cnt_m == STRAP - 1) begin
                    done_m = 1; mode_m = strap_mode; sd_m = strap_sdsel; fs_m = strap_fs;
                end
                cnt_m++;
            end
        end
        #2;
        chk("clk_o high phase", 32'(clk_o), 32'(hist[DLY-1]));
        chk("oe_o", 32'(oe_o), 32'(oe_m));
        chk("freq_sel_o", 32'(freq), 32'(fs_ovr ? cfg_fs : fs_m));
        chk("sdram_on_cpu_o", 32'(sd_cpu), 32'(sd_m));
        chk("spread_en_o", 32'(spread), 32'(op == 2'b10));
    end

    // R12: no output may be high while its source is low
    always @(negedge clk) begin
        #2;
        chk("clk_o low phase R12", 32'(clk_o), 32'h0);
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; strap_fs = 3'b101; strap_mode = 1; strap_sdsel = 1; share = 4'hF;
        fs_ovr = 0; cfg_fs = 3'b000; op = 2'b00; en = '1;
        tag = "R1";
        step(3);
        rst_n = 1;
        step(STRAP + 6);
        tag = "R2";
        strap_fs = 3'b010; strap_mode = 0; strap_sdsel = 0;
        step(6);
        tag = "R3";
        fs_ovr = 1; cfg_fs = 3'b110; step(3);
        cfg_fs = 3'b001; step(3);
        fs_ovr = 0; step(3);
        tag = "R13";
        share = 4'h0; step(8);
        share = 4'hA; step(4);
        share = 4'hF; step(4);
        tag = "R10";
        en = 27'h5A5A5A5; step(8);
        en = ~27'h5A5A5A5; step(8);
        en = '1; step(6);
        tag = "R12";
        en[0] = 1'b0; step(1);
        en[0] = 1'b1; step(8);
        tag = "R11";
        op = 2'b10; step(6);
        op = 2'b01; step(6);
        op = 2'b11; step(8);
        op = 2'b00; step(8);

        // second session: mode strap 0, SDRAM from AGP
        tag = "R4";
        rst_n = 0; strap_fs = 3'b011; strap_mode = 0; strap_sdsel = 0;
        step(3);
        rst_n = 1;
        step(STRAP + 6);
        tag = "R5";
        step(4);
        tag = "R8";
        share = 4'b1110; step(8);
        share = 4'hF; step(6);
        tag = "R7";
        share = 4'b0111; step(8);
        share = 4'hF; step(6);
        tag = "R6";
        share = 4'b1011; step(8);
        share = 4'hF; step(6);
        tag = "R9";
        share = 4'b1101; step(8);
        share = 4'hF; step(6);
        tag = "R11";
        op = 2'b11; share = 4'b1101; step(6);
        op = 2'b00; step(8);
        share = 4'hF; step(8);
        finish_run();
    end

endmodule